// File: doc/BRIEF.md
# Streaming Colour-Table Loader

The block owns a 256-colour lookup table held as 768 component bytes, three consecutive bytes (red, green, blue) per colour. Software loads the table through one 32-bit write window. Exactly one word in that window is a command port. Every other word is a plain 32-bit register that honours byte enables. A 4-bit mode field in a general configuration word, supplied by a neighbouring display block, controls what a write to the command port does. The write can set the component pointer, store one byte at the pointer and advance it, or be taken as a reserved timing write that leaves the table alone.

A scanout engine reads the table through a separate registered port. It presents a colour number and receives red, green and blue together one cycle later. A second registered port returns the contents of the plain registers.

Top module: `clut_stream_loader`

## Requirements
- R1: After reset the component pointer is 0, every table byte is 0, every plain register is 0, and both read outputs are 0.
- R2: A write to any word other than word 8 (byte offset 0x20) stores into that register only the bytes whose `wrMask` bit is set. `wrMask[b]` covers data bits 8b+7..8b. The value is visible on `regRdData` one cycle after `rdWord` selects the word.
- R3: A write to word 8 never changes any plain register. Reading word 8 returns 0.
- R4: With `genCfg[23:20]` equal to 0, a port write loads the pointer from `wrData[9:0]`. A loaded value of 768 or more sets the pointer to 0. Data bits above bit 9 are ignored.
- R5: With `genCfg[23:20]` equal to 1, a port write stores `wrData[7:0]` at the table byte the pointer selects, then adds one to the pointer.
- R6: A store at pointer 767 wraps the pointer to 0.
- R7: With `genCfg[23:21]` equal to 3'b010 (mode values 4 and 5), a port write changes neither the pointer nor the table. This check takes priority over the other mode decodes.
- R8: Mode values 2, 3 and 6 to 15 make a port write have no effect on the pointer or the table.
- R9: Table byte 3c holds red, 3c+1 green and 3c+2 blue of colour c. `pixRgb` returns {red, green, blue} in bits [23:16], [15:8] and [7:0], one cycle after `pixIdx` presents c.
- R10: Port writes ignore `wrMask`. A store happens even when the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrWord | input | 6 | Word offset of the write |
| wrData | input | 32 | Write data |
| wrMask | input | 4 | Byte enables for plain-register writes |
| genCfg | input | 32 | General configuration word; bits 23:20 are the port mode |
| rdWord | input | 6 | Register read select |
| regRdData | output | 32 | Registered register read data |
| pixIdx | input | 8 | Colour number from scanout |
| pixRgb | output | 24 | Registered {red, green, blue} of the colour |

## Verification
The internal state that matters most is the pointer, and the ports never show it directly. A wrong pointer surfaces only through the next store: that store lands on a different colour or component. The error becomes visible on `pixRgb` one cycle after the affected colour is read back. The bench therefore follows every pointer-changing action (load, wrap, reserved or idle mode, masked port write) with a store, then reads the colour the store should have reached. A misrouted register write shows on `regRdData` one cycle after the word is selected.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // Strobes from the decoder to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic idxLoad;
    logic byteStore;
    logic regWrite;
    logic cfgDrop;
  } clut_cmd_t;
endpackage

// File: rtl/clut_decode.sv
module clut_decode
  import clut_pkg::*;
#(
  parameter int REG_WORDS = 64,
  parameter int PORT_WORD = 8,
  parameter int MODE_LSB  = 20,
  localparam int WORD_W   = $clog2(REG_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [31:0]       genCfg,
  output clut_cmd_t         cmd
);
  logic [3:0] modeField;
  logic       portHit;
  logic       reservedHit;

  always_comb begin
    modeField   = genCfg[MODE_LSB +: 4];
    portHit     = wrEn && (wrWord == WORD_W'(PORT_WORD));
    // Reserved timing decode wins over the pointer and store decodes.
    reservedHit = (modeField[3:1] == 3'b010);
    cmd.regWrite  = wrEn && !portHit;
    cmd.cfgDrop   = portHit && reservedHit;
    cmd.idxLoad   = portHit && !reservedHit && (modeField == 4'd0);
    cmd.byteStore = portHit && !reservedHit && (modeField == 4'd1);
  end

  p_one_action_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.idxLoad, cmd.byteStore, cmd.regWrite, cmd.cfgDrop}));
  p_reserved_no_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && genCfg[MODE_LSB+1 +: 3] == 3'b010) |-> !(cmd.byteStore || cmd.idxLoad));
endmodule

// File: rtl/clut_datapath.sv
module clut_datapath
  import clut_pkg::*;
#(
  parameter int REG_WORDS = 64,
  parameter int PORT_WORD = 8,
  parameter int ENTRIES   = 256,
  parameter int COMPS     = 3,
  localparam int WORD_W   = $clog2(REG_WORDS),
  localparam int ENT_W    = $clog2(ENTRIES),
  localparam int BYTES    = ENTRIES * COMPS,
  localparam int IDX_W    = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  clut_cmd_t         cmd,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrMask,
  input  logic [WORD_W-1:0] rdWord,
  output logic [31:0]       regRdData,
  input  logic [ENT_W-1:0]  pixIdx,
  output logic [8*COMPS-1:0] pixRgb
);
  logic [IDX_W-1:0] compIdx;
  logic [7:0]       palMem [BYTES];
  logic [31:0]      regFile [REG_WORDS];
  logic [IDX_W-1:0] loadVal;
  logic [IDX_W-1:0] pixBase;

  assign loadVal = wrData[IDX_W-1:0];
  assign pixBase = IDX_W'(pixIdx) * IDX_W'(COMPS);

  // Component pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compIdx <= '0;
    end else if (cmd.idxLoad) begin
      compIdx <= (loadVal >= IDX_W'(BYTES)) ? '0 : loadVal;
    end else if (cmd.byteStore) begin
      compIdx <= (compIdx == IDX_W'(BYTES - 1)) ? '0 : compIdx + 1'b1;
    end
  end

  // Palette bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BYTES; i++) palMem[i] <= '0;
    end else if (cmd.byteStore) begin
      palMem[compIdx] <= wrData[7:0];
    end
  end

  // Plain registers; the port word has no storage behind it
  for (genvar w = 0; w < REG_WORDS; w++) begin : g_reg
    if (w == PORT_WORD) begin : g_port
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFile[w] <= '0;
        else       regFile[w] <= '0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regFile[w] <= '0;
        end else if (cmd.regWrite && wrWord == WORD_W'(w)) begin
          for (int b = 0; b < 4; b++)
            if (wrMask[b]) regFile[w][8*b +: 8] <= wrData[8*b +: 8];
        end
      end
    end
  end

  // Registered read ports
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
      pixRgb    <= '0;
    end else begin
      regRdData <= regFile[rdWord];
      for (int c = 0; c < COMPS; c++)
        pixRgb[8*(COMPS-1-c) +: 8] <= palMem[pixBase + IDX_W'(c)];
    end
  end

  p_idx_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    compIdx < IDX_W'(BYTES));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.byteStore && compIdx == IDX_W'(BYTES - 1)) |=> compIdx == '0);
  p_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.byteStore && compIdx != IDX_W'(BYTES - 1)) |=> compIdx == $past(compIdx) + 1'b1);
  p_drop_keeps_idx_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.cfgDrop || (!cmd.idxLoad && !cmd.byteStore)) |=> $stable(compIdx));
endmodule

// File: rtl/clut_stream_loader.sv
module clut_stream_loader
  import clut_pkg::*;
#(
  parameter int REG_WORDS = 64,
  parameter int PORT_WORD = 8,
  parameter int MODE_LSB  = 20,
  parameter int ENTRIES   = 256,
  parameter int COMPS     = 3,
  localparam int WORD_W   = $clog2(REG_WORDS),
  localparam int ENT_W    = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WORD_W-1:0]   wrWord,
  input  logic [31:0]         wrData,
  input  logic [3:0]          wrMask,
  input  logic [31:0]         genCfg,
  input  logic [WORD_W-1:0]   rdWord,
  output logic [31:0]         regRdData,
  input  logic [ENT_W-1:0]    pixIdx,
  output logic [8*COMPS-1:0]  pixRgb
);
  clut_cmd_t cmd;

  clut_decode #(
    .REG_WORDS(REG_WORDS), .PORT_WORD(PORT_WORD), .MODE_LSB(MODE_LSB)
  ) i_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWord(wrWord),
    .genCfg(genCfg), .cmd(cmd)
  );

  clut_datapath #(
    .REG_WORDS(REG_WORDS), .PORT_WORD(PORT_WORD),
    .ENTRIES(ENTRIES), .COMPS(COMPS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrWord(wrWord), .wrData(wrData),
    .wrMask(wrMask), .rdWord(rdWord), .regRdData(regRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );
endmodule

// File: tb/test_clut_stream_loader.sv
module test_clut_stream_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrWord = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrMask = '0;
  logic [31:0] genCfg = '0;
  logic [5:0]  rdWord = '0;
  logic [31:0] regRdData;
  logic [7:0]  pixIdx = '0;
  logic [23:0] pixRgb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clut_stream_loader i_clut_stream_loader (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWord(wrWord), .wrData(wrData),
    .wrMask(wrMask), .genCfg(genCfg), .rdWord(rdWord), .regRdData(regRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  // {colour, red, green, blue}
  localparam logic [31:0] TBL [8] = '{
    32'h01_102030, 32'h25_A1B2C3, 32'h40_FF0080, 32'h64_0F1E2D,
    32'h80_55AA55, 32'hC8_123456, 32'hFE_FEDCBA, 32'h4D_010203
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [5:0] w, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    wrEn = 1'b1; wrWord = w; wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic portWr(input logic [3:0] mode, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    genCfg = {8'h00, mode, 20'h0};
    wrEn = 1'b1; wrWord = 6'd8; wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkPix(input logic [7:0] c, input logic [23:0] exp, input string tag);
    @(negedge clk);
    pixIdx = c;
    @(negedge clk);
    check(tag, {8'h0, pixRgb}, {8'h0, exp});
  endtask

  task automatic chkReg(input logic [5:0] w, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdWord = w;
    @(negedge clk);
    check(tag, regRdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values on both read ports
    check("R1 pixRgb in reset", {8'h0, pixRgb}, 32'h0);
    check("R1 regRdData in reset", regRdData, 32'h0);
    rstN = 1'b1;

    // R1: pointer starts at 0, so the first store lands on colour 0 red
    portWr(4'd1, 32'h0000_003C, 4'hF);
    chkPix(8'd0, 24'h3C0000, "R1 first store at byte 0");

    // R5, R9: table-driven load and stream of colour triples
    for (int k = 0; k < 8; k++) begin
      portWr(4'd0, 32'(TBL[k][31:24]) * 3, 4'hF);
      portWr(4'd1, {24'h0, TBL[k][23:16]}, 4'hF);
      portWr(4'd1, {24'h0, TBL[k][15:8]},  4'hF);
      portWr(4'd1, {24'h0, TBL[k][7:0]},   4'hF);
    end
    for (int k = 0; k < 8; k++)
      chkPix(TBL[k][31:24], TBL[k][23:0], "R5 R9 table colour");

    // R2: byte-masked register writes
    regWr(6'd3, 32'hAABB_CCDD, 4'hF);
    regWr(6'd3, 32'h1122_3344, 4'b0101);
    chkReg(6'd3, 32'hAA22_CC44, "R2 masked merge");
    regWr(6'd63, 32'hDEAD_BEEF, 4'b1000);
    chkReg(6'd63, 32'hDE00_0000, "R2 top byte only");

    // R3: port word has no register behind it
    portWr(4'd7, 32'hFFFF_FFFF, 4'hF);
    chkReg(6'd8, 32'h0, "R3 port word reads 0");
    chkReg(6'd3, 32'hAA22_CC44, "R3 other register untouched");

    // R6: wrap from 767 to 0
    portWr(4'd0, 32'd767, 4'hF);
    portWr(4'd1, 32'h5A, 4'hF);
    portWr(4'd1, 32'h6B, 4'hF);
    chkPix(8'd255, 24'h00005A, "R6 last byte");
    chkPix(8'd0, 24'h6B0000, "R6 wrapped to byte 0");

    // R4: out-of-range load gives 0; upper data bits ignored
    portWr(4'd0, 32'd800, 4'hF);
    portWr(4'd1, 32'h77, 4'hF);
    chkPix(8'd0, 24'h770000, "R4 load of 800 gives 0");
    portWr(4'd0, 32'h0001_0006, 4'hF);
    portWr(4'd1, 32'h99, 4'hF);
    chkPix(8'd2, 24'h990000, "R4 upper data bits ignored");

    // R7: reserved modes 4 and 5 leave pointer and table alone
    portWr(4'd0, 32'd30, 4'hF);
    portWr(4'd4, 32'h01, 4'hF);
    portWr(4'd5, 32'h02, 4'hF);
    portWr(4'd1, 32'h12, 4'hF);
    portWr(4'd1, 32'h34, 4'hF);
    chkPix(8'd10, 24'h123400, "R7 reserved modes no effect");

    // R8: idle modes have no effect
    portWr(4'd0, 32'd60, 4'hF);
    portWr(4'd2, 32'hEE, 4'hF);
    portWr(4'd3, 32'hEE, 4'hF);
    portWr(4'd15, 32'hEE, 4'hF);
    portWr(4'd1, 32'h21, 4'hF);
    chkPix(8'd20, 24'h210000, "R8 idle modes no effect");

    // R10: mask ignored on the port
    portWr(4'd0, 32'd63, 4'h0);
    portWr(4'd1, 32'hAB, 4'h0);
    chkPix(8'd21, 24'hAB0000, "R10 port ignores mask");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule